// File: doc/BRIEF.md
# ATM Receive Cell Buffer with Header Check

This block sits between a line decoder and a host on the receive side of an ATM physical-layer device. It takes one decoded 8-bit character per clock and finds cell boundaries from a start-of-cell marker. It collects each 53-octet cell into a 256-character synchronous buffer and checks the header error control octet while the cell is arriving. A cell whose header check fails never becomes visible to the host. The block moves the speculative write pointer back to the point where the cell began. No byte of the bad cell can be read, and no cell count is changed.

The host reads bytes through a UTOPIA-style interface. A read is serviced only when the read address matches the configured PHY address and validated data is waiting. Each byte appears one clock after the read request. The first octet of every cell is flagged. A cell-available output shows that at least one complete, checked cell is waiting. A sticky overflow flag reports cells that were dropped for lack of room. A saturating counter reports every discarded cell.

Top module: `atm_cell_rx_fifo`

## Requirements
- R1: Each character with `in_valid` high and `in_ctrl` low that belongs to an accepted cell is stored, one per clock, and the host reads the 53 octets back in arrival order. Characters with `in_ctrl` high and idle cycles inside a cell are not stored.
- R2: Octet 4 of a cell must equal the CRC-8 of octets 0 to 3. The CRC uses generator x^8+x^2+x+1, starts from zero, takes each octet MSB first, and the result is XORed with 0x55. Any cell meeting this rule is accepted.
- R3: A cell whose octet 4 fails R2 is discarded whole. None of its octets is ever read, and `cell_avail` does not change.
- R4: With `soc_mode` = 0 (or 3), a data character with `in_soc` high is octet 0 of a new cell. A new marker before a cell is complete abandons the partial cell.
- R5: With `soc_mode` = 1, a character with `in_ctrl` high arms the block, and the next data character is octet 0. `in_soc` is ignored. A control character inside a cell abandons that cell.
- R6: With `soc_mode` = 2, `in_soc` high on a data character marks the last octet of a cell, and the next data character is octet 0. A marker on any octet other than octet 52 abandons the partial cell. A marker seen outside a cell only arms the block.
- R7: When fewer than 53 free locations remain at octet 0, the whole cell is dropped and `ovf_flag` becomes 1. It stays 1 until reset.
- R8: `cell_avail` is 1 exactly while at least one complete, validated cell is stored and has not been fully read.
- R9: A read is serviced only when `rd_en` is high, `rd_addr` equals `phy_addr` and validated data is waiting. The byte appears on `rd_data` with `rd_valid` one clock later. `rd_soc` is 1 only with octet 0 of a cell.
- R10: `err_cnt` increments by one for each discarded cell, whether the cause is a header failure, an abandoned partial cell or a lack of room. It saturates at 255.
- R11: After reset, `cell_avail`, `ovf_flag`, `rd_valid`, `rd_soc` are 0 and `err_cnt` is 0.
- R12: With the default depth of 256, four cells (212 octets) fit and a fifth unread cell is dropped by R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soc_mode | input | 2 | Start-of-cell marker option (0/3, 1, 2) |
| in_valid | input | 1 | Decoded character present |
| in_ctrl | input | 1 | Character is a control character |
| in_soc | input | 1 | Start-of-cell marker pin (modes 0 and 2) |
| in_data | input | 8 | Decoded character |
| phy_addr | input | 3 | Configured PHY address |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 3 | PHY address presented by the host |
| rd_data | output | 8 | Byte read out |
| rd_valid | output | 1 | `rd_data` holds a serviced byte |
| rd_soc | output | 1 | Byte is octet 0 of a cell |
| cell_avail | output | 1 | At least one complete validated cell waiting |
| ovf_flag | output | 1 | Sticky: a cell was dropped for lack of room |
| err_cnt | output | 8 | Saturating count of discarded cells |

## Verification
A wrong speculative or committed pointer shows up at the ports within one cell. It appears as an octet-0 byte lacking `rd_soc`, as payload shifted by the length of a rejected fragment, or as `cell_avail` staying high after 53 reads. A wrong CRC or marker decision shows on the next clock as an `err_cnt` step that was not expected, and after the last octet as a cell that appears or vanishes. The bench flips every header bit in turn, runs each marker option with its abort cases, fills the buffer past capacity and drives the error counter into saturation. It compares each byte read against arithmetically generated cells.

// File: rtl/atm_cellq_pkg.sv
`timescale 1ns/1ps
package atm_cellq_pkg;

   typedef enum logic [1:0] {
      MARK_WITH_FIRST  = 2'd0,
      MARK_CTRL_BEFORE = 2'd1,
      MARK_WITH_LAST   = 2'd2,
      MARK_RSVD        = 2'd3
   } mark_mode_e;

   localparam logic [7:0] HEC_POLY  = 8'h07;   // x^8 + x^2 + x + 1
   localparam logic [7:0] HEC_COSET = 8'h55;

   // One octet of the header CRC, MSB first.
   function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] d);
      logic [7:0] c;
      logic       fb;
      c = crc;
      for (int i = 7; i >= 0; i--) begin
         fb = c[7] ^ d[i];
         c  = {c[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
      end
      return c;
   endfunction

endpackage

// File: rtl/atm_soc_delin.sv
`timescale 1ns/1ps
module atm_soc_delin
   import atm_cellq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       valid,
   input  logic       ctrl,
   input  logic       soc,
   output logic       first,
   output logic       ctrl_mark,
   output logic       tail_mark
);

   mark_mode_e m;
   logic       armed, armed_nxt, dat;

   assign m   = mark_mode_e'(mode);
   assign dat = valid & ~ctrl;

   always_comb begin
      first     = 1'b0;
      ctrl_mark = 1'b0;
      tail_mark = 1'b0;
      armed_nxt = armed;
      case (m)
         MARK_CTRL_BEFORE: begin
            first     = dat & armed;
            ctrl_mark = valid & ctrl;
            if (valid) armed_nxt = ctrl;
         end
         MARK_WITH_LAST: begin
            first     = dat & armed;
            tail_mark = dat & soc;
            if (dat) armed_nxt = soc;
         end
         default: first = dat & soc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= armed_nxt;
   end

endmodule

// File: rtl/atm_hec_acc.sv
`timescale 1ns/1ps
module atm_hec_acc
   import atm_cellq_pkg::*;
#(
   parameter bit COSET_EN = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic       acc,
   input  logic [7:0] d,
   output logic [7:0] hec_exp
);

   logic [7:0] crc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= 8'h00;
      else if (ld)  crc <= hec_step(8'h00, d);
      else if (acc) crc <= hec_step(crc, d);
   end

   generate
      if (COSET_EN) begin : g_coset
         assign hec_exp = crc ^ HEC_COSET;
      end else begin : g_plain
         assign hec_exp = crc;
      end
   endgenerate

endmodule

// File: rtl/atm_cellq_ram.sv
`timescale 1ns/1ps
module atm_cellq_ram #(
   parameter int DW = 8,
   parameter int AW = 8
)(
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int WORDS = 1 << AW;

   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata      <= mem[raddr];
   end

endmodule

// File: rtl/atm_cell_rx_fifo.sv
`timescale 1ns/1ps
module atm_cell_rx_fifo
   import atm_cellq_pkg::*;
#(
   parameter int DEPTH    = 256,
   parameter int CELL_LEN = 53,
   parameter int HDR_LEN  = 4,
   parameter int DW       = 8,
   parameter int ADDR_W   = 3,
   parameter int ERR_W    = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        soc_mode,
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic              in_soc,
   input  logic [DW-1:0]     in_data,
   input  logic [ADDR_W-1:0] phy_addr,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic              rd_valid,
   output logic              rd_soc,
   output logic              cell_avail,
   output logic              ovf_flag,
   output logic [ERR_W-1:0]  err_cnt
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam int IW = $clog2(CELL_LEN);
   localparam logic [PW-1:0] ROOM_MAX = PW'(DEPTH - CELL_LEN);
   localparam logic [IW-1:0] LAST_IDX = IW'(CELL_LEN - 1);
   localparam logic [IW-1:0] HEC_IDX  = IW'(HDR_LEN);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (DEPTH < CELL_LEN) begin : g_bad_room
         $error("DEPTH must hold at least one cell");
      end
      if (CELL_LEN <= HDR_LEN + 1) begin : g_bad_cell
         $error("CELL_LEN must exceed header plus HEC");
      end
      if (DW != 8) begin : g_bad_dw
         $error("HEC check needs 8-bit characters");
      end
   endgenerate

   // ---------------- delineation ----------------
   logic first, ctrl_mark, tail_mark;

   atm_soc_delin u_delin (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (soc_mode),
      .valid    (in_valid),
      .ctrl     (in_ctrl),
      .soc      (in_soc),
      .first    (first),
      .ctrl_mark(ctrl_mark),
      .tail_mark(tail_mark)
   );

   // ---------------- write side ----------------
   logic          in_cell;
   logic [IW-1:0] idx;
   logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr;
   logic [PW-1:0] occ, wr_addr, wr_nxt;
   logic          data_ok, last_oct, brk, abort_prev, room;
   logic          start_ok, start_nr, cont, hec_bad, store, commit;
   logic [7:0]    hec_exp;
   logic [1:0]    n_disc;
   logic [ERR_W:0] err_sum;

   assign data_ok    = in_valid & ~in_ctrl;
   assign last_oct   = (idx == LAST_IDX);
   assign brk        = in_cell & ~first & (ctrl_mark | (tail_mark & ~last_oct));
   assign abort_prev = in_cell & (first | brk);
   assign occ        = cmt_ptr - rd_ptr;
   assign room       = (occ <= ROOM_MAX);
   assign start_ok   = first & room;
   assign start_nr   = first & ~room;
   assign cont       = in_cell & ~first & ~brk & data_ok;
   assign hec_bad    = cont & (idx == HEC_IDX) & (in_data != hec_exp);
   assign store      = start_ok | (cont & ~hec_bad);
   assign commit     = cont & last_oct;
   assign wr_addr    = start_ok ? cmt_ptr : wr_ptr;
   assign n_disc     = 2'(abort_prev) + 2'(hec_bad) + 2'(start_nr);
   assign err_sum    = {1'b0, err_cnt} + (ERR_W+1)'(n_disc);

   always_comb begin
      if (store)                     wr_nxt = wr_addr + 1'b1;
      else if (abort_prev | hec_bad) wr_nxt = cmt_ptr;
      else                           wr_nxt = wr_ptr;
   end

   atm_hec_acc #(.COSET_EN(1'b1)) u_hec (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (start_ok),
      .acc    (cont & (idx < HEC_IDX)),
      .d      (in_data),
      .hec_exp(hec_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cell  <= 1'b0;
         idx      <= '0;
         wr_ptr   <= '0;
         cmt_ptr  <= '0;
         ovf_flag <= 1'b0;
         err_cnt  <= '0;
      end else begin
         wr_ptr <= wr_nxt;
         if (commit) cmt_ptr <= wr_nxt;
         if (start_ok)            in_cell <= 1'b1;
         else if (first)          in_cell <= 1'b0;
         else if (brk | hec_bad | commit) in_cell <= 1'b0;
         if (start_ok)            idx <= IW'(1);
         else if (cont & store)   idx <= idx + 1'b1;
         if (start_nr) ovf_flag <= 1'b1;
         err_cnt <= err_sum[ERR_W] ? '1 : err_sum[ERR_W-1:0];
      end
   end

   // ---------------- read side ----------------
   logic          rd_go, rd_last;
   logic [IW-1:0] ridx;
   logic [PW-1:0] cell_cnt;

   assign rd_go      = rd_en & (rd_addr == phy_addr) & (cmt_ptr != rd_ptr);
   assign rd_last    = rd_go & (ridx == LAST_IDX);
   assign cell_avail = (cell_cnt != '0);

   atm_cellq_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk  (clk),
      .we   (store),
      .waddr(wr_addr[AW-1:0]),
      .wdata(in_data),
      .re   (rd_go),
      .raddr(rd_ptr[AW-1:0]),
      .rdata(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         ridx     <= '0;
         cell_cnt <= '0;
         rd_valid <= 1'b0;
         rd_soc   <= 1'b0;
      end else begin
         rd_valid <= rd_go;
         rd_soc   <= rd_go & (ridx == '0);
         if (rd_go) begin
            rd_ptr <= rd_ptr + 1'b1;
            ridx   <= rd_last ? '0 : ridx + 1'b1;
         end
         cell_cnt <= cell_cnt + PW'(commit) - PW'(rd_last);
      end
   end

endmodule

module atm_cell_rx_fifo_chk #(
   parameter int ADDR_W = 3,
   parameter int ERR_W  = 8,
   parameter int PW     = 9
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [ADDR_W-1:0] phy_addr,
   input logic              rd_valid,
   input logic              cell_avail,
   input logic              ovf_flag,
   input logic [ERR_W-1:0]  err_cnt,
   input logic              in_cell,
   input logic [PW-1:0]     wr_ptr,
   input logic [PW-1:0]     cmt_ptr,
   input logic [PW-1:0]     rd_ptr
);

   assert_read_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(rd_en) && ($past(rd_addr) == $past(phy_addr))));

   assert_read_needs_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(cell_avail));

   assert_avail_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cell_avail |-> (cmt_ptr != rd_ptr));

   assert_no_overflow_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   assert_err_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt != '0) |=> (err_cnt >= $past(err_cnt)));

   assert_err_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (&err_cnt) |=> (&err_cnt));

   assert_rollback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_cell |-> (wr_ptr == cmt_ptr));

endmodule

bind atm_cell_rx_fifo atm_cell_rx_fifo_chk #(
   .ADDR_W(ADDR_W), .ERR_W(ERR_W), .PW(PW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en),
   .rd_addr   (rd_addr),
   .phy_addr  (phy_addr),
   .rd_valid  (rd_valid),
   .cell_avail(cell_avail),
   .ovf_flag  (ovf_flag),
   .err_cnt   (err_cnt),
   .in_cell   (in_cell),
   .wr_ptr    (wr_ptr),
   .cmt_ptr   (cmt_ptr),
   .rd_ptr    (rd_ptr)
);

// File: tb/atm_cell_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module atm_cell_rx_fifo_tb_top;

   localparam logic [2:0] PHY = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] soc_mode = 2'd0;
   logic       in_valid = 1'b0, in_ctrl = 1'b0, in_soc = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [2:0] rd_addr = 3'd0;
   logic [7:0] rd_data;
   logic       rd_valid, rd_soc, cell_avail, ovf_flag;
   logic [7:0] err_cnt;

   int n_run = 0, n_fail = 0, exp_err = 0;

   always #2.5 clk = ~clk;

   atm_cell_rx_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .soc_mode(soc_mode),
      .in_valid(in_valid), .in_ctrl(in_ctrl), .in_soc(in_soc), .in_data(in_data),
      .phy_addr(PHY), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_soc(rd_soc),
      .cell_avail(cell_avail), .ovf_flag(ovf_flag), .err_cnt(err_cnt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c ^ d;
      repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
      return r;
   endfunction

   function automatic logic [7:0] oct(input int seed, input int i);
      logic [7:0] c;
      if (i < 4) return 8'(seed * 37 + i * 101 + 11);
      if (i == 4) begin
         c = 8'h00;
         for (int k = 0; k < 4; k++) c = crc_ref(c, 8'(seed * 37 + k * 101 + 11));
         return c ^ 8'h55;
      end
      return 8'(seed * 7 + i * 13);
   endfunction

   task automatic put(input logic [7:0] d, input logic c, input logic s);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_ctrl = c; in_soc = s;
   endtask

   task automatic gap();
      @(negedge clk);
      in_valid = 1'b0; in_ctrl = 1'b0; in_soc = 1'b0;
   endtask

   task automatic send_cell(input int seed, input int mode, input int stop_at,
                            input int soc_at, input int flip_at, input logic [7:0] mask,
                            input bit noisy);
      logic [7:0] d;
      if (mode == 1) put(8'hBC, 1'b1, 1'b0);
      for (int i = 0; i < stop_at; i++) begin
         d = oct(seed, i) ^ ((i == flip_at) ? mask : 8'h00);
         put(d, 1'b0, (mode == 0) ? (i == 0) : (mode == 2) ? (i == soc_at) : 1'b0);
         if (noisy && (i % 5 == 2)) put(8'hF7, 1'b1, 1'b0);
         if (noisy && (i % 7 == 3)) gap();
      end
      gap();
   endtask

   task automatic good(input int seed, input int mode);
      send_cell(seed, mode, 53, 52, -1, 8'h00, 1'b0);
   endtask

   task automatic read_cell(input int seed, input string req);
      for (int i = 0; i < 53; i++) begin
         @(negedge clk); rd_en = 1'b1; rd_addr = PHY;
         @(posedge clk); #1;
         chk(rd_valid && rd_data == oct(seed, i) && rd_soc == (i == 0), req,
             int'(rd_data), int'(oct(seed, i)));
      end
      @(negedge clk); rd_en = 1'b0;
   endtask

   function automatic void bump(input int n);
      exp_err = exp_err + n;
      if (exp_err > 255) exp_err = 255;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(cell_avail == 1'b0, "R11 cell_avail", int'(cell_avail), 0);
      chk(ovf_flag == 1'b0, "R11 ovf_flag", int'(ovf_flag), 0);
      chk(err_cnt == 8'd0, "R11 err_cnt", int'(err_cnt), 0);
      chk(rd_valid == 1'b0 && rd_soc == 1'b0, "R11 rd_valid", int'(rd_valid), 0);

      // R4 / R1 / R8 basic cell in marker-with-first mode
      soc_mode = 2'd0;
      good(1, 0);
      chk(cell_avail == 1'b1, "R8 avail after cell", int'(cell_avail), 1);
      read_cell(1, "R1 R4 R9 readback");
      chk(cell_avail == 1'b0, "R8 avail after read", int'(cell_avail), 0);

      // R1 control characters and gaps inside a cell are not stored
      send_cell(2, 0, 53, -1, -1, 8'h00, 1'b1);
      read_cell(2, "R1 noisy readback");

      // R2 / R3 / R10 every single header bit flipped
      for (int o = 0; o < 5; o++) begin
         for (int b = 0; b < 8; b++) begin
            send_cell(100 + o * 8 + b, 0, 53, -1, o, 8'(1 << b), 1'b0);
            bump(1);
            chk(err_cnt == 8'(exp_err), "R10 hec discard count", int'(err_cnt), exp_err);
            chk(cell_avail == 1'b0, "R3 bad cell hidden", int'(cell_avail), 0);
         end
      end

      // R2 sweep of good headers accepted
      for (int s = 0; s < 12; s++) begin
         good(200 + s * 19, 0);
         read_cell(200 + s * 19, "R2 good header");
      end

      // R9 address mismatch ignored
      good(3, 0);
      for (int a = 0; a < 8; a++) begin
         if (3'(a) == PHY) continue;
         @(negedge clk); rd_en = 1'b1; rd_addr = 3'(a);
         @(posedge clk); #1;
         chk(rd_valid == 1'b0, "R9 wrong address", int'(rd_valid), 0);
      end
      @(negedge clk); rd_en = 1'b0;
      read_cell(3, "R9 after mismatch");

      // R4 marker mid-cell abandons partial cell
      send_cell(20, 0, 10, -1, -1, 8'h00, 1'b0);
      good(21, 0);
      bump(1);
      chk(err_cnt == 8'(exp_err), "R4 R10 abort count", int'(err_cnt), exp_err);
      read_cell(21, "R4 cell after abort");
      chk(cell_avail == 1'b0, "R4 partial hidden", int'(cell_avail), 0);

      // R5 control-before marker mode
      soc_mode = 2'd1;
      put(8'h11, 1'b0, 1'b1);
      gap();
      good(30, 1);
      read_cell(30, "R5 ctrl marker");
      chk(cell_avail == 1'b0, "R5 soc pin ignored", int'(cell_avail), 0);
      send_cell(32, 1, 10, -1, -1, 8'h00, 1'b0);
      good(33, 1);
      bump(1);
      chk(err_cnt == 8'(exp_err), "R5 abort count", int'(err_cnt), exp_err);
      read_cell(33, "R5 cell after abort");

      // R6 marker-with-last mode
      soc_mode = 2'd2;
      put(8'h00, 1'b0, 1'b1);
      gap();
      good(40, 2);
      good(41, 2);
      read_cell(40, "R6 first cell");
      chk(cell_avail == 1'b1, "R8 second cell waiting", int'(cell_avail), 1);
      read_cell(41, "R6 second cell");
      send_cell(42, 2, 21, 20, -1, 8'h00, 1'b0);
      good(43, 2);
      bump(1);
      chk(err_cnt == 8'(exp_err), "R6 early marker count", int'(err_cnt), exp_err);
      read_cell(43, "R6 cell after early marker");
      chk(cell_avail == 1'b0, "R6 short cell hidden", int'(cell_avail), 0);

      // R7 / R12 capacity
      soc_mode = 2'd0;
      chk(ovf_flag == 1'b0, "R7 no overflow yet", int'(ovf_flag), 0);
      for (int c = 0; c < 5; c++) good(50 + c, 0);
      bump(1);
      chk(ovf_flag == 1'b1, "R7 overflow set", int'(ovf_flag), 1);
      chk(err_cnt == 8'(exp_err), "R7 R10 drop count", int'(err_cnt), exp_err);
      for (int c = 0; c < 4; c++) read_cell(50 + c, "R12 stored cells");
      chk(cell_avail == 1'b0, "R12 fifth cell dropped", int'(cell_avail), 0);
      chk(ovf_flag == 1'b1, "R7 overflow sticky", int'(ovf_flag), 1);

      // R10 saturation
      for (int k = 0; k < 300; k++) put(8'(k), 1'b0, 1'b1);
      gap();
      bump(299);
      chk(err_cnt == 8'd255, "R10 saturated", int'(err_cnt), 255);
      good(60, 0);
      chk(err_cnt == 8'd255, "R10 stays saturated", int'(err_cnt), 255);
      read_cell(60, "R10 cell after saturation");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule